// File: doc/BRIEF.md
# HD Timing Reference and Line Number Inserter

This block sits in the transmit path of a 20-bit high-definition video stream. Each beat carries one luma word in bits 19:10 and one chroma word in bits 9:0. The block writes the four-word timing reference sequence (TRS) into both channels at every change of horizontal blanking. After each end-of-active-video (EAV) code it can also append two line number words, taken from an internal 11-bit line counter.

Timing comes from one of two sources:
- **External mode:** the H, V and F sideband bits travel with each input beat.
- **Detect mode:** the timing is recovered from TRS codes already embedded in one chosen input channel. In this mode the sideband bits are ignored and line number insertion is locked out.

The counter is set back to line 1 by a falling edge on a dedicated per-frame input. TRS insertion and line number insertion each have their own enable.

Data moves on a valid/ready stream:
- An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- Each accepted input beat produces exactly one output beat. The output is the input beat accepted three beats earlier, after insertion.
- The first three output beats after reset are zero filler.
- `in_ready` is high whenever the output register is empty or is being drained by `out_ready`. Back-pressure from `out_ready` therefore stalls input acceptance in the same cycle.
- While stalled, the output beat holds its value.

Top module: `hd_trs_inserter`

## Requirements
- R1: With `trs_en` high, a timing event makes the beat where it occurs and the next three beats carry 3FF, 000, 000, then the XYZ word. These words are written into both the luma (19:10) and chroma (9:0) channels.
- R2: The XYZ word, from bit 9 down to bit 0, is: 1, F, V, H, V^H, F^H, F^V, F^V^H, 0, 0.
- R3: With `trs_en` low, the four words of each timing event pass through unchanged.
- R4: In external mode (`detect_en` low), a timing event is a beat whose sideband H differs from the previous beat's H. A rise of H is an EAV (H=1) and a fall of H is a start-of-active-video code (H=0). F and V are taken from that beat.
- R5: In detect mode (`detect_en` high), the sideband H, V and F bits are ignored. A timing event is the word sequence 3FF, 000, 000, XYZ in the selected channel: luma when `det_luma` is high, chroma when it is low. F, V and H are taken from bits 8, 7 and 6 of that XYZ. A prefix in the unselected channel has no effect.
- R6: The 11-bit line counter is 1 after reset. A high-to-low transition on `line_rst` sets it to 1. Otherwise it advances by one at each EAV.
- R7: After an EAV, the two beats following the XYZ carry line number words, identical in both channels. The value used is the counter value at that EAV.
  - First word: NOT L[6], L[6:0], 00.
  - Second word: 1000, L[10:7], 00.
  - These words are never appended after a start-of-active-video code.
- R8: Line number words are inserted only when `ln_en` is high and `detect_en` is low. The setting of `trs_en` does not affect them.
- R9: Exactly one output beat follows each accepted input beat, with a lag of three beats. The first three output beats after reset are zero. `out_valid` is low and `in_ready` is high after reset. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trs_en | input | 1 | Enable TRS word insertion |
| ln_en | input | 1 | Enable line number word insertion |
| detect_en | input | 1 | Take timing from embedded TRS instead of sideband bits |
| det_luma | input | 1 | Detect-mode channel: 1 = luma, 0 = chroma |
| line_rst | input | 1 | Falling edge sets the line counter to 1 |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 20 | Luma in 19:10, chroma in 9:0 |
| in_h | input | 1 | Sideband horizontal blanking bit |
| in_v | input | 1 | Sideband vertical blanking bit |
| in_f | input | 1 | Sideband field bit |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_data | output | 20 | Formatted luma and chroma |

## Verification
The bench targets the following corner cases:

- **Protection bits at several F/V/H combinations.** A wrong parity term would corrupt XYZ for only some combinations.
- **Line counter reaching values with bit 6 and bits 10:7 set.** A mis-sliced line word would pass at small line numbers and fail there.
- **Falling-edge reset of the counter mid-stream.** An edge detector keyed on the wrong polarity would leave the count running.
- **Detect mode with toggling sideband bits and a decoy prefix in the unselected channel.** A design that leaked the pins or watched the wrong channel would insert spurious TRS there, or would append line words it must lock out.
- **Random-length output stalls.** A broken ready rule would drop or duplicate beats, shifting every later word.

// File: rtl/hdtrs_pkg.sv
package hdtrs_pkg;
  localparam int CH_W       = 10;
  localparam int N_CH       = 2;
  localparam int BUS_W      = CH_W * N_CH;
  localparam int LN_W       = 11;
  localparam int PREFIX_LEN = 3;
  localparam int IDX_W      = 3;

  localparam logic [CH_W-1:0] WORD_ONES = '1;
  localparam logic [CH_W-1:0] WORD_ZERO = '0;

  typedef enum logic [1:0] {PF_IDLE, PF_ONES, PF_Z1, PF_Z2} pf_state_e;

  // status word: marker, field/vertical/horizontal, four protection bits
  function automatic logic [CH_W-1:0] xyz_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  function automatic logic [CH_W-1:0] ln_first(input logic [LN_W-1:0] n);
    return {~n[6], n[6:0], 2'b00};
  endfunction

  function automatic logic [CH_W-1:0] ln_second(input logic [LN_W-1:0] n);
    return {4'b1000, n[10:7], 2'b00};
  endfunction
endpackage

// File: rtl/hdtrs_delay.sv
module hdtrs_delay #(
  parameter int DEPTH = 3,
  parameter int W     = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] din,
  output logic [W-1:0] tail
);
  logic [W-1:0] stage [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage[i] <= '0;
      end else if (adv) begin
        if (i == 0) stage[i] <= din;
        else        stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
    end
  end

  assign tail = stage[DEPTH-1];
endmodule

// File: rtl/hdtrs_detect.sv
module hdtrs_detect
  import hdtrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             sel_luma,
  input  logic [BUS_W-1:0] bus,
  output logic             hit,
  output logic             f,
  output logic             v,
  output logic             h
);
  logic [CH_W-1:0] word;
  pf_state_e       st;

  assign word = sel_luma ? bus[BUS_W-1 -: CH_W] : bus[CH_W-1:0];
  assign hit  = (st == PF_Z2);
  assign f    = word[CH_W-2];
  assign v    = word[CH_W-3];
  assign h    = word[CH_W-4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PF_IDLE;
    end else if (adv) begin
      if (word == WORD_ONES)                     st <= PF_ONES;
      else if (st == PF_ONES && word == WORD_ZERO) st <= PF_Z1;
      else if (st == PF_Z1 && word == WORD_ZERO)   st <= PF_Z2;
      else                                       st <= PF_IDLE;
    end
  end

  AST_PREFIX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && hit && word != WORD_ONES) |=> (st == PF_IDLE)); // R5
endmodule

// File: rtl/hdtrs_linecnt.sv
module hdtrs_linecnt #(
  parameter int W = hdtrs_pkg::LN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line_rst,
  input  logic         step,
  output logic [W-1:0] count
);
  logic rst_q;
  logic fall;

  assign fall = rst_q && !line_rst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_q <= 1'b0;
      count <= W'(1);
    end else begin
      rst_q <= line_rst;
      if (fall)      count <= W'(1);
      else if (step) count <= count + W'(1);
    end
  end

  AST_LINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (count == W'(1))); // R6
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !fall) |=> (count == W'($past(count) + W'(1)))); // R6
endmodule

// File: rtl/hdtrs_seq.sv
module hdtrs_seq
  import hdtrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             trig,
  input  logic             t_f,
  input  logic             t_v,
  input  logic             t_h,
  input  logic             ln_allow,
  input  logic [LN_W-1:0]  line_in,
  output logic             active_now,
  output logic [IDX_W-1:0] idx_now,
  output logic             lat_f,
  output logic             lat_v,
  output logic             lat_h,
  output logic [LN_W-1:0]  line_lat
);
  localparam logic [IDX_W-1:0] TRS_LAST = IDX_W'(PREFIX_LEN);
  localparam logic [IDX_W-1:0] LN_LAST  = IDX_W'(PREFIX_LEN + 2);

  logic             run;
  logic             ln_go;
  logic [IDX_W-1:0] idx;

  assign active_now = trig || run;
  assign idx_now    = trig ? '0 : idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; idx <= '0; ln_go <= 1'b0;
      lat_f <= 1'b0; lat_v <= 1'b0; lat_h <= 1'b0; line_lat <= '0;
    end else if (adv) begin
      if (trig) begin
        run <= 1'b1; idx <= IDX_W'(1);
        lat_f <= t_f; lat_v <= t_v; lat_h <= t_h;
        ln_go <= ln_allow && t_h;
        line_lat <= line_in;
      end else if (run) begin
        if ((idx == TRS_LAST && !ln_go) || idx == LN_LAST) begin
          run <= 1'b0; idx <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  AST_SEQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && trig) |=> (run && idx == IDX_W'(1))); // R1
  AST_LN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && trig && !ln_allow) |=> !ln_go); // R8
  AST_LN_AFTER_EAV: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idx > TRS_LAST) |-> (ln_go && lat_h)); // R7
endmodule

// File: rtl/hd_trs_inserter.sv
module hd_trs_inserter
  import hdtrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trs_en,
  input  logic             ln_en,
  input  logic             detect_en,
  input  logic             det_luma,
  input  logic             line_rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  input  logic             in_h,
  input  logic             in_v,
  input  logic             in_f,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_data
);
  localparam int BEAT_W = BUS_W + 3;
  localparam logic [IDX_W-1:0] FIRST_LN = IDX_W'(PREFIX_LEN + 1);

  logic              acc;
  logic [BEAT_W-1:0] tail;
  logic [BUS_W-1:0]  head_data;
  logic              head_h, head_v, head_f, prev_h;
  logic              det_hit, det_f, det_v, det_h;
  logic              trig, t_f, t_v, t_h;
  logic              active_now, lat_f, lat_v, lat_h;
  logic [IDX_W-1:0]  idx_now;
  logic [LN_W-1:0]   line_cnt, line_lat;
  logic [CH_W-1:0]   trs_word, ln_word;
  logic [BUS_W-1:0]  next_data;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  hdtrs_delay #(.DEPTH(PREFIX_LEN), .W(BEAT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .adv(acc),
    .din({in_data, in_h, in_v, in_f}), .tail(tail));

  assign head_data = tail[BEAT_W-1:3];
  assign head_h    = tail[2];
  assign head_v    = tail[1];
  assign head_f    = tail[0];

  hdtrs_detect u_detect (
    .clk(clk), .rst_n(rst_n), .adv(acc), .sel_luma(det_luma), .bus(in_data),
    .hit(det_hit), .f(det_f), .v(det_v), .h(det_h));

  always_ff @(posedge clk) begin
    if (!rst_n)   prev_h <= 1'b0;
    else if (acc) prev_h <= head_h;
  end

  assign trig = detect_en ? det_hit : (head_h != prev_h);
  assign t_f  = detect_en ? det_f : head_f;
  assign t_v  = detect_en ? det_v : head_v;
  assign t_h  = detect_en ? det_h : head_h;

  hdtrs_linecnt #(.W(LN_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_rst(line_rst),
    .step(acc && trig && t_h), .count(line_cnt));

  hdtrs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .adv(acc), .trig(trig),
    .t_f(t_f), .t_v(t_v), .t_h(t_h),
    .ln_allow(ln_en && !detect_en), .line_in(line_cnt),
    .active_now(active_now), .idx_now(idx_now),
    .lat_f(lat_f), .lat_v(lat_v), .lat_h(lat_h), .line_lat(line_lat));

  always_comb begin
    unique case (idx_now)
      IDX_W'(0):          trs_word = WORD_ONES;
      IDX_W'(1),
      IDX_W'(2):          trs_word = WORD_ZERO;
      default:            trs_word = xyz_word(lat_f, lat_v, lat_h);
    endcase
  end

  assign ln_word = (idx_now == FIRST_LN) ? ln_first(line_lat) : ln_second(line_lat);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
    logic [CH_W-1:0] lane_in;
    assign lane_in = head_data[ch*CH_W +: CH_W];
    assign next_data[ch*CH_W +: CH_W] =
        !active_now            ? lane_in :
        (idx_now < FIRST_LN)   ? (trs_en ? trs_word : lane_in) :
                                 ln_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (acc) begin
      out_valid <= 1'b1;
      out_data  <= next_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_TRS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && trig && trs_en) |=> (out_data == {N_CH{WORD_ONES}})); // R1
  AST_QUIET_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && detect_en && !det_hit && !active_now) |=> (out_data == $past(head_data))); // R5
endmodule

// File: tb/test_hd_trs_inserter.sv
`timescale 1ns/1ps
module test_hd_trs_inserter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, trs_en = 1'b0, ln_en = 1'b0, detect_en = 1'b0, det_luma = 1'b0;
  logic line_rst = 1'b0, in_valid = 1'b0, in_h = 1'b0, in_v = 1'b0, in_f = 1'b0;
  logic out_ready = 1'b1;
  logic [19:0] in_data = '0;
  logic in_ready, out_valid;
  logic [19:0] out_data;

  hd_trs_inserter i_hd_trs_inserter (
    .clk(clk), .rst_n(rst_n), .trs_en(trs_en), .ln_en(ln_en), .detect_en(detect_en),
    .det_luma(det_luma), .line_rst(line_rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_h(in_h), .in_v(in_v), .in_f(in_f), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  int n_chk = 0, n_err = 0, cyc = 0, nb = 0, nrec = 0;
  logic [19:0] inw [4096];
  logic [19:0] exw [4096];
  logic        bh [4096], bv [4096], bf [4096], pulse [4096];
  logic [19:0] rec [4200];
  logic        bp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R2 encoding, computed from the requirement
  function automatic logic [9:0] xyz(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction
  // R7 encodings
  function automatic logic [9:0] lnw0(input int n);
    logic [10:0] l = 11'(n);
    return {~l[6], l[6:0], 2'b00};
  endfunction
  function automatic logic [9:0] lnw1(input int n);
    logic [10:0] l = 11'(n);
    return {4'b1000, l[10:7], 2'b00};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  always @(posedge clk) begin
    #1;
    if (bp_on) out_ready = (cyc % 3) != 0;
    else       out_ready = 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) nrec = 0;
    else begin
      if (out_valid && out_ready) begin
        rec[nrec] = out_data;
        nrec++;
      end
      if (bp_on && out_valid && !out_ready)
        chk(in_ready == 1'b0, "R9 stall", {19'd0, in_ready}, 20'd0);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic add(input logic [19:0] d, input logic h, input logic v, input logic f,
                     input logic [19:0] e);
    inw[nb] = d; bh[nb] = h; bv[nb] = v; bf[nb] = f; exw[nb] = e; pulse[nb] = 1'b0;
    nb++;
  endtask

  task automatic beat(input logic [19:0] d, input logic h, input logic v, input logic f);
    in_valid = 1'b1; in_data = d; in_h = h; in_v = v; in_f = f;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pulse_line();
    line_rst = 1'b1;
    @(posedge clk); #1;
    line_rst = 1'b0;
    @(posedge clk); #1;
  endtask

  // one line: 6 active beats (H=0) then 6 blanking beats (H=1)
  task automatic ext_line(input logic f, input logic v, input bit trs_on, input bit ln_on,
                          input int line, input bit first);
    for (int k = 0; k < 12; k++) begin
      logic [9:0] y, c, w;
      logic [19:0] d, e;
      logic h;
      y = 10'h100 + 10'(nb % 200);
      c = 10'h040 + 10'(nb % 200);
      d = {y, c};
      h = (k >= 6);
      e = d;
      if (k < 4 && !first && trs_on) begin
        w = (k == 0) ? 10'h3FF : (k == 3) ? xyz(f, v, 1'b0) : 10'h000;
        e = {w, w};
      end
      if (k >= 6 && k < 10 && trs_on) begin
        w = (k == 6) ? 10'h3FF : (k == 9) ? xyz(f, v, 1'b1) : 10'h000;
        e = {w, w};
      end
      if (k == 10 && ln_on) e = {lnw0(line), lnw0(line)};
      if (k == 11 && ln_on) e = {lnw1(line), lnw1(line)};
      add(d, h, v, f, e);
    end
  endtask

  task automatic play(input string req);
    logic lh, lv, lf;
    do_reset();
    for (int i = 0; i < nb; i++) begin
      if (pulse[i]) pulse_line();
      beat(inw[i], bh[i], bv[i], bf[i]);
    end
    lh = bh[nb-1]; lv = bv[nb-1]; lf = bf[nb-1];
    repeat (3) beat(20'h0, lh, lv, lf);
    repeat (12) @(posedge clk);
    #1;
    chk(nrec == nb + 3, {req, " R9 beat count"}, 20'(nrec), 20'(nb + 3));
    for (int i = 0; i < 3; i++) chk(rec[i] == 20'h0, "R9 filler", rec[i], 20'h0);
    for (int i = 0; i < nb && i + 3 < nrec; i++)
      chk(rec[i+3] == exw[i], req, rec[i+3], exw[i]);
    nb = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 reset valid", {19'd0, out_valid}, 20'd0);
    chk(in_ready == 1'b1, "R9 reset ready", {19'd0, in_ready}, 20'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_ext_trs();   // R1 R2 R4
    trs_en = 1; ln_en = 0; detect_en = 0;
    ext_line(0, 0, 1, 0, 0, 1);
    ext_line(0, 1, 1, 0, 0, 0);
    ext_line(1, 1, 1, 0, 0, 0);
    ext_line(1, 0, 1, 0, 0, 0);
    play("R1 R2 R4 external TRS");
  endtask

  task automatic t_trs_off();   // R3
    trs_en = 0; ln_en = 0; detect_en = 0;
    ext_line(0, 0, 0, 0, 0, 1);
    ext_line(1, 0, 0, 0, 0, 0);
    play("R3 pass-through");
  endtask

  task automatic t_line_numbers();   // R6 R7
    trs_en = 1; ln_en = 1; detect_en = 0;
    for (int n = 1; n <= 130; n++) ext_line(0, 0, 1, 1, n, n == 1);
    pulse[nb] = 1'b0;
    ext_line(1, 0, 1, 1, 1, 0);
    pulse[nb - 12] = 1'b1;
    ext_line(1, 0, 1, 1, 2, 0);
    play("R6 R7 line numbers");
  endtask

  task automatic t_ln_no_trs();   // R8 R3
    trs_en = 0; ln_en = 1; detect_en = 0;
    ext_line(0, 0, 0, 1, 1, 1);
    ext_line(0, 0, 0, 1, 2, 0);
    play("R8 line words without TRS");
  endtask

  task automatic t_detect(input bit luma);   // R5 R8
    logic [9:0] p [4];
    logic [19:0] d, e;
    trs_en = 1; ln_en = 1; detect_en = 1; det_luma = luma;
    p[0] = 10'h3FF; p[1] = 10'h000; p[2] = 10'h000;
    add(luma ? {10'h150, 10'h0A0} : {10'h0A0, 10'h150}, 1, 1, 0,
        luma ? {10'h150, 10'h0A0} : {10'h0A0, 10'h150});
    for (int r = 0; r < 2; r++) begin
      p[3] = (r == 0) ? 10'h380 : 10'h240;
      for (int k = 0; k < 4; k++) begin
        logic [9:0] w;
        w = (k < 3) ? p[k] : xyz(p[3][8], p[3][7], p[3][6]);
        d = luma ? {p[k], 10'h0A1 + 10'(k)} : {10'h0A1 + 10'(k), p[k]};
        add(d, k[0], ~k[0], k[0], {w, w});
      end
      for (int k = 0; k < 3; k++) begin
        d = {10'h160 + 10'(k), 10'h0B0 + 10'(k)};
        add(d, ~k[0], 0, 1, d);
      end
    end
    for (int k = 0; k < 4; k++) begin
      logic [9:0] q;
      q = (k < 3) ? p[k] : 10'h274;
      d = luma ? {10'h170 + 10'(k), q} : {q, 10'h170 + 10'(k)};
      add(d, k[0], 1, 0, d);
    end
    add(20'h12345, 1, 0, 0, 20'h12345);
    play(luma ? "R5 R8 detect luma" : "R5 R8 detect chroma");
    detect_en = 0;
  endtask

  task automatic t_backpressure();   // R9
    trs_en = 1; ln_en = 1; detect_en = 0; bp_on = 1'b1;
    for (int n = 1; n <= 5; n++) ext_line(n[0], 0, 1, 1, n, n == 1);
    play("R9 back-pressure");
    bp_on = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ext_trs();
    t_trs_off();
    t_line_numbers();
    t_ln_no_trs();
    t_detect(1'b1);
    t_detect(1'b0);
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule